// File: doc/BRIEF.md
# Multicast Hash Table Filter

This block hashes a six-byte destination address into a 6-bit index and looks that index up in a 64-entry table. Software loads the table one byte at a time. The host side of the receive path presents the address bytes one per cycle with a valid strobe. The first byte may be marked with a frame-start pulse, or the pulse may come alone in the cycle before the first byte. The block folds each byte into a 32-bit CRC register, eight bit steps per clock. When the sixth byte arrives, it forms the index from the top of the updated CRC, reads the table and registers the result.

The result is a one-cycle done strobe with a hit flag alongside it. The hit flag is forced low unless the hash enable input was high when the sixth byte was accepted. Whatever sits downstream makes the final accept or reject decision for the frame.

Top module: `mhf_top`

## Requirements
- R1: After reset, done and hit are 0 and every table bit is 0, so an enabled lookup misses until the table is written.
- R2: A frame_start pulse loads the CRC with all ones and clears the byte count. A byte with byte_valid in the same cycle is hashed as the first byte. A frame_start with byte_valid low makes the next valid byte the first byte.
- R3: Each byte is taken least significant bit first in eight steps. In each step the feedback is CRC bit 31 XOR the data bit, the CRC shifts left by one, and a feedback of 1 XORs the CRC with 0x04C11DB6 and then sets bit 0.
- R4: Table index bit i equals bit 31-i of the CRC after the sixth byte, for i from 0 to 5.
- R5: A write with tbl_addr = n loads tbl_wdata bits 7..0 into table bits 8n+7..8n. The new value takes effect from the next clock edge.
- R6: The hit flag is the table bit at the index when hash_en is 1 in the cycle the sixth byte is accepted.
- R7: When hash_en is 0 in the cycle the sixth byte is accepted, hit is 0 whatever the table holds.
- R8: done is high for exactly the one cycle after the sixth byte is accepted, and hit is never 1 while done is 0.
- R9: Valid bytes after the sixth are ignored and produce no further done until the next frame_start.
- R10: A frame_start part way through an address discards the partial hash, and the result depends only on the bytes that follow it.
- R11: Cycles with byte_valid low leave the CRC and the byte count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Restart hashing for a new address |
| byte_valid | input | 1 | byte_data holds an address byte |
| byte_data | input | 8 | Address byte, first byte first |
| hash_en | input | 1 | Enables lookup; hit is 0 when this is low |
| tbl_wr | input | 1 | Table byte write strobe |
| tbl_addr | input | 3 | Table byte select |
| tbl_wdata | input | 8 | Table byte write data |
| done | output | 1 | One-cycle pulse after the sixth byte |
| hit | output | 1 | Lookup result, valid with done |

## Verification
The in-line assertions check these on every cycle:
- done lasts a single cycle, and hit never appears without done.
- A lone frame_start reloads the CRC with all ones and gives no result in the cycle after it.
- The byte count never passes six.
- A disabled lookup never reports a hit.
- A table write lands in the addressed byte.

Only the bench scenarios can show that the hash itself is right. They do this by comparing hits against an independently computed index under selective table contents. The same scenarios show that gaps, restarts and surplus bytes change the result exactly as required.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
    localparam int unsigned CRC_W = 32;
    typedef logic [CRC_W-1:0] crc_t;

    // One serial step: shift, then fold in the polynomial and set bit 0 on feedback
    function automatic crc_t crc_step(input crc_t c, input logic d, input crc_t poly);
        logic fb;
        crc_t n;
        fb = c[CRC_W-1] ^ d;
        n  = c << 1;
        if (fb) begin
            n = (n ^ poly) | crc_t'(1);
        end
        return n;
    endfunction
endpackage

// File: rtl/mhf_crc_byte.sv
module mhf_crc_byte
    import mhf_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter crc_t        POLY   = 32'h04C11DB6
) (
    input  crc_t              crc_in,
    input  logic [BYTE_W-1:0] data_in,
    output crc_t              crc_out
);
    crc_t stage [BYTE_W+1];

    assign stage[0] = crc_in;

    // Unrolled chain, least significant data bit first
    for (genvar k = 0; k < BYTE_W; k++) begin : g_step
        assign stage[k+1] = crc_step(stage[k], data_in[k], POLY);
    end

    assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/mhf_table.sv
module mhf_table #(
    parameter int unsigned IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [$clog2(((1 << IDX_W) + 7) / 8)-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_bit
);
    localparam int unsigned TBL_BITS  = 1 << IDX_W;
    localparam int unsigned TBL_BYTES = (TBL_BITS + 7) / 8;
    localparam int unsigned SEL_W     = $clog2(TBL_BYTES);

    logic [TBL_BITS-1:0] tbl_d, tbl_q;
    logic [7:0]          lane_d [TBL_BYTES];

    for (genvar g = 0; g < TBL_BYTES; g++) begin : g_lane
        assign lane_d[g] = (wr_en && wr_addr == SEL_W'(g)) ? wr_data : tbl_q[8*g +: 8];
    end

    always_comb begin
        tbl_d = tbl_q;
        for (int i = 0; i < TBL_BYTES; i++) begin
            tbl_d[8*i +: 8] = lane_d[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_bit = tbl_q[rd_idx];

    // R5: the addressed byte holds the written data one edge later
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tbl_q[$past(wr_addr)*8 +: 8] == $past(wr_data));
endmodule

// File: rtl/mhf_top.sv
module mhf_top
    import mhf_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned IDX_W      = 6,
    parameter crc_t        POLY       = 32'h04C11DB6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       hash_en,
    input  logic       tbl_wr,
    input  logic [2:0] tbl_addr,
    input  logic [7:0] tbl_wdata,
    output logic       done,
    output logic       hit
);
    localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);

    typedef struct packed {
        crc_t             crc;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             hit;
    } state_t;

    state_t           s_d, s_q;
    crc_t             base_crc, crc_next;
    logic [CNT_W-1:0] base_cnt;
    logic [IDX_W-1:0] idx;
    logic             tbl_bit;
    logic             accept;

    mhf_crc_byte #(.BYTE_W(8), .POLY(POLY)) u_crc (
        .crc_in  (base_crc),
        .data_in (byte_data),
        .crc_out (crc_next)
    );

    mhf_table #(.IDX_W(IDX_W)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr),
        .wr_addr (tbl_addr),
        .wr_data (tbl_wdata),
        .rd_idx  (idx),
        .rd_bit  (tbl_bit)
    );

    // Index is the top IDX_W CRC bits in reversed order
    always_comb begin
        for (int i = 0; i < IDX_W; i++) begin
            idx[i] = crc_next[CRC_W-1-i];
        end
    end

    always_comb begin
        base_crc = frame_start ? '1 : s_q.crc;
        base_cnt = frame_start ? '0 : s_q.cnt;
        accept   = byte_valid && (base_cnt < CNT_W'(ADDR_BYTES));

        s_d      = s_q;
        s_d.crc  = base_crc;
        s_d.cnt  = base_cnt;
        s_d.done = 1'b0;
        s_d.hit  = 1'b0;
        if (accept) begin
            s_d.crc = crc_next;
            s_d.cnt = base_cnt + CNT_W'(1);
            if (base_cnt == CNT_W'(ADDR_BYTES - 1)) begin
                s_d.done = 1'b1;
                s_d.hit  = hash_en & tbl_bit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{crc: '1, cnt: '0, done: 1'b0, hit: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign done = s_q.done;
    assign hit  = s_q.hit;

    // R8: single-cycle done, hit only alongside done
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_hit_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> done);
    // R7: a lookup made while disabled reports a miss
    a_r7_disabled_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(hash_en)) |-> !hit);
    // R2: lone frame_start reloads the CRC with all ones
    a_r2_crc_init: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !byte_valid) |=> (s_q.crc == '1));
    // R10: a restart is never followed at once by a result
    a_r10_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !byte_valid) |=> !done);
    // R9: byte count never passes the address length
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(ADDR_BYTES));
endmodule

// File: tb/tb_mhf_top.sv
`timescale 1ns/1ps
module tb_mhf_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       hash_en = 1'b0;
    logic       tbl_wr = 1'b0;
    logic [2:0] tbl_addr = '0;
    logic [7:0] tbl_wdata = '0;
    logic       done, hit;

    int checks = 0;
    int errors = 0;
    int done_seen = 0;
    int done_want = 0;
    logic [63:0] mtab = '0;
    bit    exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    mhf_top dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_valid(byte_valid),
        .byte_data(byte_data), .hash_en(hash_en), .tbl_wr(tbl_wr), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .done(done), .hit(hit)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference index per R3/R4
    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c;
        logic [5:0]  r;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int b = 0; b < 6; b++) begin
            for (int k = 0; k < 8; k++) begin
                fb = c[31] ^ a[8*b + k];
                c  = c << 1;
                if (fb) c = (c ^ 32'h04C1_1DB6) | 32'd1;
            end
        end
        for (int i = 0; i < 6; i++) r[i] = c[31-i];
        return r;
    endfunction

    task automatic tbl_write(input int n, input logic [7:0] v);
        @(negedge clk);
        tbl_wr = 1'b1; tbl_addr = 3'(n); tbl_wdata = v;
        mtab[8*n +: 8] = v;
        @(negedge clk);
        tbl_wr = 1'b0;
    endtask

    task automatic fill_table(input logic [7:0] v);
        for (int n = 0; n < 8; n++) tbl_write(n, v);
    endtask

    // Driver: pushes the expected result when the sixth byte goes out
    task automatic send_frame(input logic [47:0] a, input int gap, input int extra,
                              input bit sep_start, input string tag);
        if (sep_start) begin
            @(negedge clk);
            frame_start = 1'b1; byte_valid = 1'b0;
        end
        for (int b = 0; b < 6; b++) begin
            @(negedge clk);
            frame_start = (b == 0) && !sep_start;
            byte_valid  = 1'b1;
            byte_data   = a[8*b +: 8];
            if (b == 5) begin
                exp_q.push_back(hash_en && mtab[ref_idx(a)]);
                tag_q.push_back(tag);
                done_want++;
            end
            for (int g = 0; g < gap && b < 5; g++) begin
                @(negedge clk);
                frame_start = 1'b0; byte_valid = 1'b0; byte_data = 8'hA5;
            end
        end
        for (int e = 0; e < extra; e++) begin
            @(negedge clk);
            frame_start = 1'b0; byte_valid = 1'b1; byte_data = 8'(8'h3C + e);
        end
        @(negedge clk);
        frame_start = 1'b0; byte_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Monitor: compares results against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (hit && !done) chk(1'b0, "R8 hit without done", 1, 0);
            if (done) begin
                done_seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected done", 1, 0);
                end else begin
                    automatic bit    e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    chk(hit == e, t, int'(hit), int'(e));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    localparam logic [47:0] ADDR_A = 48'h5E00_0001_0001; // bytes 01 00 01 00 00 5E
    localparam logic [47:0] ADDR_B = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] ADDR_C = 48'h0C0B_0A03_0201;

    initial begin
        logic [5:0] ia;
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && hit == 1'b0, "R1 reset outputs", int'({done, hit}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R1 done idle after reset", int'(done), 0);

        hash_en = 1'b1;
        send_frame(ADDR_A, 0, 0, 1'b0, "R1 cleared table misses");

        fill_table(8'hFF);
        send_frame(ADDR_A, 0, 0, 1'b0, "R6 full table hit A");
        send_frame(ADDR_B, 0, 0, 1'b0, "R6 full table hit B");
        send_frame(ADDR_C, 2, 0, 1'b0, "R11 gaps between bytes");

        // Single selected bit: exercises R3, R4 and R5 byte lanes
        ia = ref_idx(ADDR_A);
        fill_table(8'h00);
        tbl_write(int'(ia[5:3]), 8'(1 << ia[2:0]));
        send_frame(ADDR_A, 0, 0, 1'b0, "R4 selected bit hit");
        send_frame(ADDR_B, 0, 0, 1'b0, "R3 other address vs selected bit");
        send_frame(ADDR_C, 0, 0, 1'b0, "R3 third address vs selected bit");
        tbl_write(int'(ia[5:3]), 8'(1 << ia[2:0]) ^ 8'hFF);
        send_frame(ADDR_A, 0, 0, 1'b0, "R5 neighbour bits only miss");
        tbl_write(int'(ia[5:3]), 8'hFF);
        send_frame(ADDR_A, 1, 0, 1'b1, "R2 lone frame_start then bytes");

        hash_en = 1'b0;
        fill_table(8'hFF);
        send_frame(ADDR_A, 0, 0, 1'b0, "R7 disabled miss");
        hash_en = 1'b1;

        send_frame(ADDR_B, 0, 3, 1'b0, "R9 frame with surplus bytes");
        chk(done_seen == done_want, "R9 no extra done", done_seen, done_want);

        // Partial junk address, then restart
        fill_table(8'h00);
        tbl_write(int'(ref_idx(ADDR_C) >> 3), 8'(1 << ref_idx(ADDR_C)[2:0]));
        @(negedge clk);
        frame_start = 1'b1; byte_valid = 1'b1; byte_data = 8'h77;
        @(negedge clk);
        frame_start = 1'b0; byte_data = 8'h12;
        @(negedge clk);
        byte_data = 8'h34;
        send_frame(ADDR_C, 0, 0, 1'b0, "R10 restart discards partial");

        repeat (5) @(negedge clk);
        chk(done_seen == done_want, "R8 every frame gave one done", done_seen, done_want);
        chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule